// File: doc/BRIEF.md
# Sub-slot D channel extractor

This block works on a serial time-division multiplexed frame of 64 time slots, each eight bits wide, so 512 bit periods per frame. One bit arrives on every rising clock edge, and a frame sync pulse marks the first bit of slot 0. Software selects a two-bit field by giving a 6-bit slot number and a 2-bit sub-slot number. The block collects that field from the receive stream once per frame and reports it with a one-cycle valid strobe.

On the transmit side, the block drives a two-bit word into the same field position of an outgoing stream. It raises an output enable only while that field is on the line.

A new selection is held in a pending register. It takes effect only at the next frame sync, so the field never moves partway through a frame.

Top module: `subslot_dchan_port`

## Requirements
- R1: After synchronous reset (`rst` high for at least one edge), `rx_valid` is 0, `rx_field` is 0, `tx_oe` is 0 and `tx_dout` is 1, and the slot and sub-slot selection is slot 0, sub-slot 0.
- R2: The bit sampled on the edge where `frame_sync` is high is frame position 0. Each later edge advances the position by one, wrapping from 511 to 0. The selected field occupies positions slot*8 + sub*2 and slot*8 + sub*2 + 1. Bits within a slot are MSB first, so sub-slot 0 holds the two most significant bits.
- R3: The first bit received in the field becomes `rx_field[1]` and the second becomes `rx_field[0]`. `rx_field` and a one-cycle `rx_valid` pulse appear just after the edge that samples the field's second bit.
- R4: Exactly one `rx_valid` pulse is produced per complete frame.
- R5: A value written with `cfg_wr` in the middle of a frame does not change the field used in that frame. It applies from the next `frame_sync`.
- R6: Before the first `frame_sync` after reset, neither `rx_valid` nor `tx_oe` is ever asserted, whatever the data input does.
- R7: `tx_oe` is high for exactly the two cycles that follow the edges sampling the field's two positions. During those cycles `tx_dout` carries the transmit word MSB first.
- R8: Whenever `tx_oe` is low, `tx_dout` is 1 (idle).
- R9: `tx_word` is captured on the frame sync edge. Changes to it later in the frame do not affect what that frame transmits.
- R10: If `frame_sync` arrives before the field's second bit, the count restarts at position 0 and the partly received field is discarded without a valid pulse.
- R11: A reset in mid-frame discards the partial frame and returns the selection to slot 0, sub-slot 0. Nothing is produced until the next `frame_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one line bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | High during bit 0 of slot 0 |
| rx_din | input | 1 | Serial receive data |
| cfg_wr | input | 1 | Writes the pending slot and sub-slot selection |
| cfg_slot | input | 6 | Slot number, 0 to 63 |
| cfg_sub | input | 2 | Sub-slot number, 0 to 3 |
| tx_word | input | 2 | Word to send in the selected field |
| rx_field | output | 2 | Last received field value |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_field` |
| tx_dout | output | 1 | Serial transmit data, 1 when idle |
| tx_oe | output | 1 | High while `tx_dout` carries the field |

## Verification
The results arrive at fixed times:
- `rx_valid` and `rx_field` change just after the edge that samples the field's second position.
- `tx_oe` and `tx_dout` for a position hold for the whole cycle after the edge that samples that position.
- A selection written mid-frame shows up only in the following frame.

The bench changes inputs on falling edges and reads outputs one nanosecond after each rising edge. It labels every sample with the frame position just taken in, so each expectation is compared in exactly the cycle it is due.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

    parameter int SLOT_BITS  = 8;
    parameter int NUM_SLOTS  = 64;
    parameter int FIELD_BITS = 2;

    localparam int FRAME_BITS = SLOT_BITS * NUM_SLOTS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
    localparam int SUBS       = SLOT_BITS / FIELD_BITS;
    localparam int SUB_IDX_W  = $clog2(SUBS);
    localparam int FIDX_W     = (FIELD_BITS > 1) ? $clog2(FIELD_BITS) : 1;

    typedef logic [POS_W-1:0]      pos_t;
    typedef logic [FIELD_BITS-1:0] field_t;
    typedef logic [FIDX_W-1:0]     fidx_t;

    // slot/sub-slot selection as written by software
    typedef struct packed {
        logic [SLOT_IDX_W-1:0] slot;
        logic [SUB_IDX_W-1:0]  sub;
    } sel_cfg_t;

    // a frame position and whether a frame is in progress
    typedef struct packed {
        pos_t pos;
        logic live;
    } frame_pos_t;

    function automatic pos_t field_start(sel_cfg_t c);
        return pos_t'(c.slot) * pos_t'(SLOT_BITS) + pos_t'(c.sub) * pos_t'(FIELD_BITS);
    endfunction

    function automatic logic in_field(pos_t p, pos_t s);
        return (p >= s) && ((p - s) < pos_t'(FIELD_BITS));
    endfunction

    function automatic fidx_t field_idx(pos_t p, pos_t s);
        pos_t d;
        d = p - s;
        return d[FIDX_W-1:0];
    endfunction

endpackage

// File: rtl/dchan_frame_timer.sv
module dchan_frame_timer
    import dchan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_sync,
    output frame_pos_t cur,
    output frame_pos_t held
);

    pos_t pos_q;
    logic live_q;

    // position of the bit being sampled on the coming edge
    always_comb begin
        cur.live = frame_sync | live_q;
        if (frame_sync) begin
            cur.pos = '0;
        end else if (pos_q == pos_t'(FRAME_BITS - 1)) begin
            cur.pos = '0;
        end else begin
            cur.pos = pos_q + pos_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            live_q <= 1'b0;
        end else begin
            pos_q  <= cur.pos;
            live_q <= cur.live;
        end
    end

    // position sampled on the previous edge (drives the transmit side)
    assign held.pos  = pos_q;
    assign held.live = live_q;

endmodule

// File: rtl/dchan_sel_shadow.sv
module dchan_sel_shadow
    import dchan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_sync,
    input  logic     cfg_wr,
    input  sel_cfg_t cfg_in,
    output pos_t     rx_start,
    output pos_t     tx_start
);

    sel_cfg_t pend_q;
    sel_cfg_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (cfg_wr) begin
                pend_q <= cfg_in;
            end
            if (frame_sync) begin
                act_q <= pend_q;
            end
        end
    end

    // on the sync edge the pending value already governs position 0
    assign rx_start = field_start(frame_sync ? pend_q : act_q);
    assign tx_start = field_start(act_q);

endmodule

// File: rtl/dchan_rx_capture.sv
module dchan_rx_capture
    import dchan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_pos_t cur,
    input  pos_t       start,
    input  logic       rx_din,
    output field_t     field,
    output logic       valid
);

    field_t part_q;
    field_t part_d;
    field_t data_q;
    logic   valid_q;
    logic   hit;
    logic   last;
    fidx_t  idx;

    always_comb begin
        hit    = cur.live && in_field(cur.pos, start);
        idx    = field_idx(cur.pos, start);
        last   = hit && (idx == fidx_t'(FIELD_BITS - 1));
        part_d = part_q;
        if (hit) begin
            for (int k = 0; k < FIELD_BITS; k++) begin
                if (idx == fidx_t'(k)) begin
                    part_d[FIELD_BITS-1-k] = rx_din;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q  <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            part_q  <= part_d;
            valid_q <= last;
            if (last) begin
                data_q <= part_d;
            end
        end
    end

    assign field = data_q;
    assign valid = valid_q;

endmodule

// File: rtl/dchan_tx_drive.sv
module dchan_tx_drive
    import dchan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_sync,
    input  field_t     word_in,
    input  frame_pos_t held,
    input  pos_t       start,
    output logic       dout,
    output logic       oe
);

    field_t word_q;
    fidx_t  idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (frame_sync) begin
            word_q <= word_in;
        end
    end

    always_comb begin
        oe   = held.live && in_field(held.pos, start);
        idx  = field_idx(held.pos, start);
        dout = 1'b1;
        if (oe) begin
            for (int k = 0; k < FIELD_BITS; k++) begin
                if (idx == fidx_t'(k)) begin
                    dout = word_q[FIELD_BITS-1-k];
                end
            end
        end
    end

endmodule

// File: rtl/subslot_dchan_port.sv
module subslot_dchan_port
    import dchan_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_sync,
    input  logic                  rx_din,
    input  logic                  cfg_wr,
    input  logic [SLOT_IDX_W-1:0] cfg_slot,
    input  logic [SUB_IDX_W-1:0]  cfg_sub,
    input  logic [FIELD_BITS-1:0] tx_word,
    output logic [FIELD_BITS-1:0] rx_field,
    output logic                  rx_valid,
    output logic                  tx_dout,
    output logic                  tx_oe
);

    frame_pos_t cur_w;
    frame_pos_t held_w;
    sel_cfg_t   cfg_w;
    pos_t       rx_start_w;
    pos_t       act_start_w;

    assign cfg_w.slot = cfg_slot;
    assign cfg_w.sub  = cfg_sub;

    dchan_frame_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .cur        (cur_w),
        .held       (held_w)
    );

    dchan_sel_shadow u_sel (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .cfg_wr     (cfg_wr),
        .cfg_in     (cfg_w),
        .rx_start   (rx_start_w),
        .tx_start   (act_start_w)
    );

    dchan_rx_capture u_rx (
        .clk    (clk),
        .rst    (rst),
        .cur    (cur_w),
        .start  (rx_start_w),
        .rx_din (rx_din),
        .field  (rx_field),
        .valid  (rx_valid)
    );

    dchan_tx_drive u_tx (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .word_in    (tx_word),
        .held       (held_w),
        .start      (act_start_w),
        .dout       (tx_dout),
        .oe         (tx_oe)
    );

endmodule

// File: rtl/dchan_port_checker.sv
module dchan_port_checker
    import dchan_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic frame_sync,
    input logic rx_valid,
    input logic tx_oe,
    input logic tx_dout,
    input pos_t act_start
);

    logic seen_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_sync <= 1'b0;
        end else if (frame_sync) begin
            seen_sync <= 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rx_valid && !tx_oe && tx_dout));

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_sel_frame_only_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> $stable(act_start));

    assert_silent_until_sync_R6: assert property (@(posedge clk) disable iff (rst)
        !seen_sync |-> (!rx_valid && !tx_oe));

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        !tx_oe |-> tx_dout);

endmodule

bind subslot_dchan_port dchan_port_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .rx_valid   (rx_valid),
    .tx_oe      (tx_oe),
    .tx_dout    (tx_dout),
    .act_start  (act_start_w)
);

// File: tb/subslot_dchan_port_test.sv
module subslot_dchan_port_test;

    localparam int FRAME = 512;

    // {slot, sub, received field, transmit word}
    localparam logic [11:0] VEC [8] = '{
        {6'd0,  2'd0, 2'b10, 2'b01},
        {6'd63, 2'd3, 2'b01, 2'b10},
        {6'd0,  2'd3, 2'b11, 2'b00},
        {6'd31, 2'd2, 2'b00, 2'b11},
        {6'd17, 2'd1, 2'b10, 2'b10},
        {6'd40, 2'd0, 2'b01, 2'b01},
        {6'd5,  2'd1, 2'b11, 2'b10},
        {6'd62, 2'd2, 2'b00, 2'b01}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_sync = 1'b0;
    logic       rx_din = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_slot = '0;
    logic [1:0] cfg_sub = '0;
    logic [1:0] tx_word = '0;
    logic [1:0] rx_field;
    logic       rx_valid;
    logic       tx_dout;
    logic       tx_oe;

    int n_checks = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    subslot_dchan_port uut (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .rx_din     (rx_din),
        .cfg_wr     (cfg_wr),
        .cfg_slot   (cfg_slot),
        .cfg_sub    (cfg_sub),
        .tx_word    (tx_word),
        .rx_field   (rx_field),
        .rx_valid   (rx_valid),
        .tx_dout    (tx_dout),
        .tx_oe      (tx_oe)
    );

    function automatic logic filler(int p);
        return p[0] ^ p[2] ^ p[5];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // runs n bit periods starting with a frame sync; field expected at 'start'
    task automatic run_frame(input int n, input int start, input logic [1:0] rxv,
                             input logic [1:0] txw, input bit do_wr, input int wr_at,
                             input logic [5:0] ws, input logic [1:0] wsub);
        int vcnt = 0;
        int vat = -1;
        int tx_bad = 0;
        logic [1:0] got = '0;
        for (int p = 0; p < n; p++) begin
            bit exp_oe;
            @(negedge clk);
            frame_sync = (p == 0);
            rx_din     = (p >= start && p < start + 2) ? rxv[1 - (p - start)] : filler(p);
            tx_word    = (p == 0) ? txw : ~txw;
            cfg_wr     = do_wr && (p == wr_at);
            cfg_slot   = ws;
            cfg_sub    = wsub;
            @(posedge clk);
            #1;
            if (rx_valid) begin
                vcnt++;
                vat = p;
                got = rx_field;
            end
            exp_oe = (p == start) || (p == start + 1);
            if (tx_oe !== exp_oe) tx_bad++;
            if (exp_oe && tx_dout !== txw[1 - (p - start)]) tx_bad++;
            if (!tx_oe && tx_dout !== 1'b1) tx_bad++;
        end
        @(negedge clk);
        frame_sync = 1'b0;
        cfg_wr = 1'b0;
        if (start + 1 < n) begin
            check(vcnt == 1, "R4 one valid per frame", vcnt, 1);
            check(vat == start + 1, "R3 valid at second field bit", vat, start + 1);
            check(got == rxv, "R2 field value at slot/sub position", got, rxv);
        end else begin
            check(vcnt == 0, "R10 partial field discarded", vcnt, 0);
        end
        check(tx_bad == 0, "R7 R9 transmit window and word", tx_bad, 0);
    endtask

    // free-running bits with no frame sync
    task automatic idle(input int n, input string req);
        int seen = 0;
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            frame_sync = 1'b0;
            cfg_wr = 1'b0;
            rx_din = filler(p);
            @(posedge clk);
            #1;
            if (rx_valid || tx_oe) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic check_reset_state(input string req);
        check(rx_valid === 1'b0, req, rx_valid, 0);
        check(tx_oe === 1'b0, req, tx_oe, 0);
        check(tx_dout === 1'b1, req, tx_dout, 1);
        check(rx_field === 2'b00, req, rx_field, 0);
    endtask

    initial begin
        #(4 * 100000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_reset_state("R1 reset state");

        // R6: no sync yet, nothing comes out
        idle(600, "R6 silent before first sync");

        // select first vector before any frame
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_slot = VEC[0][11:6];
        cfg_sub = VEC[0][5:4];
        @(negedge clk);
        cfg_wr = 1'b0;

        // table: each frame writes the next selection mid-frame (R5)
        for (int i = 0; i < 8; i++) begin
            logic [5:0] ns;
            logic [1:0] nsub;
            int st;
            st = VEC[i][11:6] * 8 + VEC[i][5:4] * 2;
            if (i < 7) begin
                ns = VEC[i+1][11:6];
                nsub = VEC[i+1][5:4];
            end else begin
                ns = 6'd5;
                nsub = 2'd1;
            end
            run_frame(FRAME, st, VEC[i][3:2], VEC[i][1:0], 1'b1, 200, ns, nsub);
        end

        // R10: sync arrives right after the field's first bit (start 42)
        run_frame(43, 42, 2'b10, 2'b01, 1'b0, 0, 6'd0, 2'd0);
        run_frame(FRAME, 42, 2'b01, 2'b11, 1'b1, 100, 6'd3, 2'd2);

        // R11: reset in mid-frame with slot 3 sub 2 (start 28) pending use
        run_frame(20, 28, 2'b11, 2'b01, 1'b0, 0, 6'd0, 2'd0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_reset_state("R11 R1 reset in mid-frame");
        idle(40, "R11 nothing after reset until sync");
        run_frame(FRAME, 0, 2'b11, 2'b10, 1'b0, 0, 6'd0, 2'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule